// File: doc/BRIEF.md
# Four-Set Associative Tag Directory with Victim Choice

This block keeps the tags and valid bits of a cache with four sets and a parameterised number of ways. A lookup address is split into a byte offset, a two-bit set index and a tag. The tag is compared against every way of the indexed set at once, and the block reports a hit and the way that matched in the same cycle. For the same set it also names the way that a refill should use. An empty way is always chosen first. When the set is full, a policy input selects among least-recently-used, first-in-first-out and pseudo-random choice.

A refill command writes the tag and sets the valid bit of one way of one set on the next clock edge. Recency is updated on every fill and on every lookup that hits. The FIFO position of a set moves only when that set is refilled, so it reflects load order rather than access order. Data storage, the memory side and write handling belong to other blocks.

Top module: `cache_set_dir`

## Requirements
- R1: With OFF_W offset bits, the set index is address bits [OFF_W+1:OFF_W] and the tag is every bit above them. The low OFF_W bits never affect any output.
- R2: `hit` is 1 in the same cycle as `lk_valid` when a valid way of the indexed set holds the lookup tag. `hit_way` then gives that way, the lowest one if several match. When there is no hit, `hit` and `hit_way` are 0.
- R3: A `fill_valid` cycle writes the tag of `fill_addr` into way `fill_way` of its set and marks that way valid at the clock edge. From the next cycle on, a lookup of that block hits.
- R4: If the indexed set of `lk_addr` has an invalid way, `victim_way` is the lowest-numbered invalid way, whatever the policy.
- R5: With `policy_sel` = 0 and a full set, `victim_way` is the least recently used way of the set. Each fill, and each lookup hit in a cycle without a fill, makes the touched way the most recent one.
- R6: With `policy_sel` = 1 and a full set, `victim_way` is a per-set pointer. The pointer steps by one, modulo the way count, on every fill of that set. Lookups never move it.
- R7: With `policy_sel` = 2 and a full set, `victim_way` is the low bits of a 16-bit LFSR. The LFSR shifts left on every clock once reset has ended, takes bit15^bit13^bit12^bit10 into bit 0, and starts from 16'hACE1.
- R8: `rst_n` is asserted asynchronously and takes effect at once. After reset, all ways are invalid, the FIFO pointers are 0, and the recency order of each set runs from way 0 (oldest) to way WAYS-1 (newest). The internal reset ends on the second rising clock edge after `rst_n` goes high.
- R9: `policy_sel` = 3 behaves exactly like `policy_sel` = 0.
- R10: When a fill and a lookup hit occur in the same cycle, only the fill updates the recency order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup byte address |
| fill_valid | input | 1 | Refill command |
| fill_addr | input | ADDR_W | Byte address of the block being filled |
| fill_way | input | log2(WAYS) | Way that receives the fill |
| policy_sel | input | 2 | 0 LRU, 1 FIFO, 2 LFSR random, 3 LRU |
| hit | output | 1 | Lookup hit |
| hit_way | output | log2(WAYS) | Matching way, 0 when there is no hit |
| victim_way | output | log2(WAYS) | Way to refill for the set of `lk_addr` |

## Verification
Every output is combinational from the stored state, so a wrong valid bit, tag, recency order or FIFO pointer shows up in the first cycle a lookup reaches that set. A corrupted valid bit or tag appears as a wrong `hit` or `hit_way`. Wrong replacement state appears as a wrong `victim_way` once the set is full and the matching policy is selected. An LFSR that is off by a single step changes the random victim within a few cycles. The bench therefore compares all three outputs in every cycle against a model it keeps itself, and it switches policies often so that each piece of replacement state is observed.

// File: rtl/setdir_pkg.sv
package setdir_pkg;
  localparam int unsigned SET_CNT = 4;
  localparam int unsigned SET_W   = 2;
  localparam int unsigned RND_W   = 16;
  localparam logic [15:0] RND_SEED = 16'hACE1;

  typedef enum logic [1:0] {
    POL_LRU  = 2'd0,
    POL_FIFO = 2'd1,
    POL_RAND = 2'd2,
    POL_LRU3 = 2'd3
  } repl_pol_e;
endpackage

// File: rtl/setdir_tags.sv
module setdir_tags
  import setdir_pkg::*;
#(
  parameter int unsigned TAG_W = 12,
  parameter int unsigned WAYS  = 4,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [SET_W-1:0] rd_set,
  input  logic [TAG_W-1:0] rd_tag,
  output logic [WAYS-1:0]  rd_valid,
  output logic [WAYS-1:0]  rd_match
);
  logic [WAYS-1:0]  valid_q [SET_CNT];
  logic [WAYS-1:0]  valid_d [SET_CNT];
  logic [TAG_W-1:0] tag_q   [SET_CNT][WAYS];

  always_comb begin
    valid_d = valid_q;
    valid_d[wr_set][wr_way] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(SET_CNT); s++) valid_q[s] <= '0;
    end else if (wr_en) begin
      valid_q <= valid_d;
    end
  end

  // Tag array carries no reset; valid bits qualify it.
  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
  end

  // One comparator per way, only the indexed set is read.
  generate
    for (genvar w = 0; w < int'(WAYS); w++) begin : g_cmp
      assign rd_match[w] = valid_q[rd_set][w] && (tag_q[rd_set][w] == rd_tag);
    end
  endgenerate

  assign rd_valid = valid_q[rd_set];
endmodule

// File: rtl/setdir_lru.sv
module setdir_lru
  import setdir_pkg::*;
#(
  parameter int unsigned WAYS = 4,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] lru_way
);
  localparam logic [WAY_W-1:0] AGE_MAX = WAY_W'(WAYS - 1);

  // Age 0 is most recent, AGE_MAX is least recent; ages form a permutation.
  logic [WAY_W-1:0] age_q [SET_CNT][WAYS];
  logic [WAY_W-1:0] age_d [SET_CNT][WAYS];
  logic [WAY_W-1:0] ref_age;

  always_comb begin
    age_d   = age_q;
    ref_age = age_q[touch_set][touch_way];
    for (int w = 0; w < int'(WAYS); w++) begin
      if (age_q[touch_set][w] < ref_age) age_d[touch_set][w] = age_q[touch_set][w] + 1'b1;
    end
    age_d[touch_set][touch_way] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(SET_CNT); s++)
        for (int w = 0; w < int'(WAYS); w++)
          age_q[s][w] <= WAY_W'(int'(WAYS) - 1 - w);
    end else if (touch_en) begin
      age_q <= age_d;
    end
  end

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < int'(WAYS); w++) begin
      if (age_q[rd_set][w] == AGE_MAX) lru_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/setdir_fifo.sv
module setdir_fifo
  import setdir_pkg::*;
#(
  parameter int unsigned WAYS = 4,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  logic [SET_W-1:0] adv_set,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] fifo_way
);
  logic [WAY_W-1:0] ptr_q [SET_CNT];
  logic [WAY_W-1:0] ptr_d [SET_CNT];

  always_comb begin
    ptr_d = ptr_q;
    ptr_d[adv_set] = ptr_q[adv_set] + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(SET_CNT); s++) ptr_q[s] <= '0;
    end else if (adv_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign fifo_way = ptr_q[rd_set];
endmodule

// File: rtl/setdir_lfsr.sv
module setdir_lfsr
  import setdir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [RND_W-1:0] rnd_q
);
  logic [RND_W-1:0] rnd_d;

  always_comb begin
    rnd_d = {rnd_q[RND_W-2:0], rnd_q[15] ^ rnd_q[13] ^ rnd_q[12] ^ rnd_q[10]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rnd_q <= RND_SEED;
    else        rnd_q <= rnd_d;
  end
endmodule

// File: rtl/cache_set_dir.sv
module cache_set_dir
  import setdir_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 2,
  parameter int unsigned WAYS   = 4,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned TAG_W = ADDR_W - OFF_W - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [1:0]        policy_sel,
  output logic              hit,
  output logic [WAY_W-1:0]  hit_way,
  output logic [WAY_W-1:0]  victim_way
);
  // Reset: asynchronous assert, release after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Address split.
  logic [SET_W-1:0] lk_set, fill_set;
  logic [TAG_W-1:0] lk_tag, fill_tag;
  assign lk_set   = lk_addr[OFF_W +: SET_W];
  assign fill_set = fill_addr[OFF_W +: SET_W];
  assign lk_tag   = lk_addr[ADDR_W-1 -: TAG_W];
  assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0]  set_valid, set_match;
  logic [WAY_W-1:0] lru_way, fifo_way, match_idx, free_idx;
  logic [RND_W-1:0] rnd_q;
  logic             touch_en;
  logic [SET_W-1:0] touch_set;
  logic [WAY_W-1:0] touch_way;
  repl_pol_e        pol;

  setdir_tags #(.TAG_W(TAG_W), .WAYS(WAYS)) u_tags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (fill_valid),
    .wr_set   (fill_set),
    .wr_way   (fill_way),
    .wr_tag   (fill_tag),
    .rd_set   (lk_set),
    .rd_tag   (lk_tag),
    .rd_valid (set_valid),
    .rd_match (set_match)
  );

  // A fill owns the recency update in its cycle; otherwise a hit touches.
  assign touch_en  = fill_valid | hit;
  assign touch_set = fill_valid ? fill_set : lk_set;
  assign touch_way = fill_valid ? fill_way : hit_way;

  setdir_lru #(.WAYS(WAYS)) u_lru (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .touch_en  (touch_en),
    .touch_set (touch_set),
    .touch_way (touch_way),
    .rd_set    (lk_set),
    .lru_way   (lru_way)
  );

  setdir_fifo #(.WAYS(WAYS)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .adv_en   (fill_valid),
    .adv_set  (fill_set),
    .rd_set   (lk_set),
    .fifo_way (fifo_way)
  );

  setdir_lfsr u_lfsr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .rnd_q (rnd_q)
  );

  // Lowest-index priority encoders for matches and free ways.
  always_comb begin
    match_idx = '0;
    free_idx  = '0;
    for (int w = int'(WAYS) - 1; w >= 0; w--) begin
      if (set_match[w])  match_idx = WAY_W'(w);
      if (!set_valid[w]) free_idx  = WAY_W'(w);
    end
  end

  assign hit     = lk_valid & (|set_match);
  assign hit_way = hit ? match_idx : '0;
  assign pol     = repl_pol_e'(policy_sel);

  always_comb begin
    if (!(&set_valid)) begin
      victim_way = free_idx;
    end else begin
      unique case (pol)
        POL_FIFO: victim_way = fifo_way;
        POL_RAND: victim_way = rnd_q[WAY_W-1:0];
        default:  victim_way = lru_way;
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^{lk_addr[OFF_W-1:0], fill_addr[OFF_W-1:0], rnd_q[RND_W-1:WAY_W]};
endmodule

// File: rtl/setdir_chk.sv
module setdir_chk
  import setdir_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 2,
  parameter int unsigned WAYS   = 4,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              fill_valid,
  input logic [ADDR_W-1:0] fill_addr,
  input logic [1:0]        policy_sel,
  input logic              hit,
  input logic [WAY_W-1:0]  hit_way,
  input logic [WAY_W-1:0]  victim_way,
  input logic [WAYS-1:0]   set_valid,
  input logic [RND_W-1:0]  rnd_q
);
  // R8: nothing is valid while the internal reset is held.
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_empty_r8: assert (set_valid == '0);
    end
  end

  // R2: a reported hit names a valid way of a requested lookup.
  p_hit_way_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (lk_valid && set_valid[hit_way]));

  // R3: the block filled last cycle hits now.
  p_hit_after_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_valid) && lk_valid &&
     lk_addr[ADDR_W-1:OFF_W] == $past(fill_addr[ADDR_W-1:OFF_W])) |-> hit);

  // R4: with room in the set, the victim is an empty way.
  p_victim_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&set_valid)) |-> !set_valid[victim_way]);

  // R6: a fill of a full set moves the FIFO victim forward by one.
  p_fifo_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_sel == 2'd1 && $past(policy_sel) == 2'd1 && $past(fill_valid) &&
     $past(&set_valid) && $stable(lk_addr[OFF_W +: SET_W]) &&
     $past(fill_addr[OFF_W +: SET_W]) == $past(lk_addr[OFF_W +: SET_W]))
    |-> victim_way == WAY_W'($past(victim_way) + 1'b1));

  // R7: the LFSR never locks up in the all-zero state.
  p_lfsr_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_q != '0);
endmodule

bind cache_set_dir setdir_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .WAYS(WAYS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .lk_valid   (lk_valid),
  .lk_addr    (lk_addr),
  .fill_valid (fill_valid),
  .fill_addr  (fill_addr),
  .policy_sel (policy_sel),
  .hit        (hit),
  .hit_way    (hit_way),
  .victim_way (victim_way),
  .set_valid  (set_valid),
  .rnd_q      (rnd_q)
);

// File: tb/tb_cache_set_dir.sv
module tb_cache_set_dir;
  localparam int ADDR_W = 16;
  localparam int OFF_W  = 2;
  localparam int WAYS   = 4;
  localparam int WAY_W  = 2;
  localparam int TAG_W  = ADDR_W - OFF_W - 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b1;
  logic              lk_valid = 1'b0;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic              fill_valid = 1'b0;
  logic [ADDR_W-1:0] fill_addr = '0;
  logic [WAY_W-1:0]  fill_way = '0;
  logic [1:0]        policy_sel = '0;
  logic              hit;
  logic [WAY_W-1:0]  hit_way;
  logic [WAY_W-1:0]  victim_way;

  always #5 clk = ~clk;

  cache_set_dir #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .WAYS(WAYS)) dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_way(fill_way),
    .policy_sel(policy_sel), .hit(hit), .hit_way(hit_way), .victim_way(victim_way)
  );

  // Reference state.
  bit             mv  [4][WAYS];
  logic [TAG_W-1:0] mt [4][WAYS];
  int             age [4][WAYS];
  int             ptr [4];
  logic [15:0]    ml;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic int set_of(logic [ADDR_W-1:0] a);
    return int'(a[OFF_W +: 2]);
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic int model_hit_way(logic [ADDR_W-1:0] a);
    for (int w = 0; w < WAYS; w++)
      if (mv[set_of(a)][w] && mt[set_of(a)][w] == tag_of(a)) return w;
    return -1;
  endfunction

  function automatic int model_victim(int s, int pol);
    for (int w = 0; w < WAYS; w++) if (!mv[s][w]) return w;
    if (pol == 1) return ptr[s];
    if (pol == 2) return int'(ml[WAY_W-1:0]);
    for (int w = 0; w < WAYS; w++) if (age[s][w] == WAYS - 1) return w;
    return 0;
  endfunction

  function automatic string victim_tag(int s, int pol);
    for (int w = 0; w < WAYS; w++) if (!mv[s][w]) return "R4";
    if (pol == 1) return "R6";
    if (pol == 2) return "R7";
    if (pol == 3) return "R9";
    return "R5";
  endfunction

  function automatic void touch(int s, int w);
    int ref_age = age[s][w];
    for (int v = 0; v < WAYS; v++) if (age[s][v] < ref_age) age[s][v]++;
    age[s][w] = 0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One clock: drive at negedge, check before the rising edge, update model after it.
  task automatic cycle(bit lkv, logic [ADDR_W-1:0] la, bit fv, logic [ADDR_W-1:0] fa,
                       int fw, int pol, string req, string vreq);
    int eh, ev, fway;
    lk_valid   = lkv;
    lk_addr    = la;
    policy_sel = 2'(pol);
    fway       = (fw < 0) ? model_victim(set_of(fa), pol) : fw;
    fill_valid = fv;
    fill_addr  = fa;
    fill_way   = WAY_W'(fway);
    #1;
    eh = lkv ? model_hit_way(la) : -1;
    ev = model_victim(set_of(la), pol);
    chk((req == "") ? "R2" : req, "hit", int'(hit), (eh >= 0) ? 1 : 0);
    chk((req == "") ? "R2" : req, "hit_way", int'(hit_way), (eh >= 0) ? eh : 0);
    chk((vreq == "") ? victim_tag(set_of(la), pol) : vreq, "victim_way", int'(victim_way), ev);
    @(posedge clk);
    if (fv) begin
      mv[set_of(fa)][fway] = 1'b1;
      mt[set_of(fa)][fway] = tag_of(fa);
      touch(set_of(fa), fway);
      ptr[set_of(fa)] = (ptr[set_of(fa)] + 1) % WAYS;
    end else if (eh >= 0) begin
      touch(set_of(la), eh);
    end
    ml = {ml[14:0], ml[15] ^ ml[13] ^ ml[12] ^ ml[10]};
    @(negedge clk);
  endtask

  function automatic logic [ADDR_W-1:0] mk(int t, int s, int off);
    return {TAG_W'(t), 2'(s), OFF_W'(off)};
  endfunction

  initial begin
    logic [ADDR_W-1:0] a;
    int pol;
    void'($urandom(32'd4242));
    #1 rst_n = 1'b0;
    for (int s = 0; s < 4; s++) begin
      ptr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin
        mv[s][w] = 1'b0; mt[s][w] = '0; age[s][w] = WAYS - 1 - w;
      end
    end
    ml = 16'hACE1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);

    // R8: reset state, lookup misses, victim way 0
    cycle(1, mk(1, 0, 0), 0, '0, 0, 0, "R8", "R8");
    // R4: fill set 0 in order 0..3 through the invalid-first victim
    for (int t = 1; t <= 4; t++) cycle(1, mk(t, 0, 0), 1, mk(t, 0, 0), -1, 0, "", "R4");
    // R1: offset bits differ, same block still hits
    cycle(1, mk(1, 0, 3), 0, '0, 0, 0, "R1", "");
    // R5: way 0 recently hit, LRU victim of a missing block is way 1
    cycle(1, mk(9, 0, 1), 0, '0, 0, 0, "", "R5");
    // R10: hit on way 1 while filling way 3; only the fill counts
    cycle(1, mk(2, 0, 0), 1, mk(7, 0, 0), 3, 0, "R10", "");
    cycle(1, mk(9, 0, 0), 0, '0, 0, 0, "", "R10");
    // R9: policy 3 matches LRU
    cycle(1, mk(9, 0, 0), 0, '0, 0, 3, "", "R9");
    // R6: FIFO pointer of set 0 after five fills
    cycle(1, mk(9, 0, 0), 0, '0, 0, 1, "", "R6");
    // R7: random victim
    cycle(1, mk(9, 0, 0), 0, '0, 0, 2, "", "R7");
    // R3: fill then look up next cycle
    cycle(0, mk(5, 2, 0), 1, mk(5, 2, 0), 2, 0, "", "");
    cycle(1, mk(5, 2, 2), 0, '0, 0, 0, "R3", "");

    // Constrained random traffic over a small tag pool.
    pol = 0;
    for (int i = 0; i < 4000; i++) begin
      bit lkv, fv;
      logic [ADDR_W-1:0] fa;
      int fw;
      if (i % 64 == 0) pol = int'($urandom_range(0, 3));
      a   = mk(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
      lkv = ($urandom_range(0, 9) < 7);
      fv  = 0; fa = a; fw = -1;
      if (lkv && model_hit_way(a) < 0 && $urandom_range(0, 9) < 6) fv = 1;
      else if ($urandom_range(0, 19) == 0) begin
        fv = 1;
        fa = mk(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)), 0);
        fw = int'($urandom_range(0, WAYS - 1));
      end
      cycle(lkv, a, fv, fa, fw, pol, "", "");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule